// File: doc/BRIEF.md
# Synchronous FIFO with Replay and Half-Full Status

This block is a first-in/first-out buffer that stores 9-bit words, which leaves room for a parity or control bit beside each byte. The depth is a parameter that may be 256, 512 or 1024 words. Data enters on an active-low write strobe and leaves on an active-low read strobe. All strobes are sampled on the rising clock edge. Two internal ring pointers generate the storage addresses, so the block has no address input.

The block drives three registered status outputs: empty, full and half-full. These come from a small level state machine with four states. `LVL_EMPTY` means the buffer holds no words. `LVL_LOWER` means it holds between 1 and DEPTH/2 words. `LVL_UPPER` means it holds between DEPTH/2+1 and DEPTH-1 words. `LVL_FULL` means it holds DEPTH words.

Every clock edge takes the transition chosen by the next occupancy. Moves go from any state to `LVL_EMPTY` when the next occupancy is 0, to `LVL_FULL` when it equals DEPTH, to `LVL_UPPER` when it is above DEPTH/2, and to `LVL_LOWER` otherwise. A normal write or read changes the occupancy by one, so only neighbouring states are reached in normal use. A replay, described next, can jump to any state.

An active-low replay input moves the read pointer back to the start of storage. The words written since reset can then be read out again. The write pointer does not move. Replay gives correct data only while no more than DEPTH words have been written since reset. An active-low asynchronous reset clears both pointers.

Top module: `fifo_rt_hf`

## Requirements
- R1: While reset is low and on the first cycle after it is released, empty is 1, full is 0, half_full is 0 and dout is 0.
- R2: Words are read out in the order they were written. dout takes the new word on the clock edge that samples rd_n low, and it holds that word until the next accepted read.
- R3: full rises on the edge that accepts the DEPTH-th unread word. A write sampled while full is ignored: the stored words and the occupancy are unchanged, so later reads return only the earlier data.
- R4: A read sampled while empty is ignored: dout keeps its value and empty stays 1.
- R5: half_full is 1 exactly when the occupancy is at least DEPTH/2+1. It is 0 when the occupancy is DEPTH/2 or less. The flag is updated on the same edge as the occupancy.
- R6: When a write and a read are both sampled and both are accepted, both take effect in that cycle and the occupancy is unchanged. When the buffer is full, the read is accepted and the write is dropped.
- R7: An edge that samples rexmit_n low sets the read pointer to its reset position and leaves the write pointer unchanged. The flags are then recomputed, so the occupancy equals the number of words written since reset. The reads that follow return those words again from the first one.
- R8: On an edge that samples rexmit_n low, wr_n and rd_n are ignored and dout does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rexmit_n | input | 1 | Replay request, active low |
| din | input | WIDTH (9) | Word to be written |
| dout | output | WIDTH (9) | Most recently read word |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| half_full | output | 1 | Occupancy is above DEPTH/2 |

## Verification
The assertions assume that the strobes are clean synchronous levels. They also assume that replay is requested only while at most DEPTH words have been written since reset; outside that range the pointer difference no longer reflects the data. The bench keeps within both limits. It drives every strobe once per cycle on the falling edge. It issues its single replay while the total number of words written is exactly DEPTH. Only after that replay does it go on to the simultaneous read-and-write traffic that pushes the write count past DEPTH.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
    typedef enum logic [1:0] {
        LVL_EMPTY = 2'd0,
        LVL_LOWER = 2'd1,
        LVL_UPPER = 2'd2,
        LVL_FULL  = 2'd3
    } level_e;
endpackage

// File: rtl/fifo_ptrs.sv
module fifo_ptrs #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic          rd_go,
    input  logic          rewind,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   occ,
    output logic [AW:0]   occ_next
);
    localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

    logic [AW:0] wr_q, rd_q, wr_d, rd_d;

    always_comb begin
        wr_d = wr_q + {{AW{1'b0}}, wr_go};
        rd_d = rewind ? '0 : rd_q + {{AW{1'b0}}, rd_go};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            wr_q <= wr_d;
            rd_q <= rd_d;
        end
    end

    assign wr_addr  = wr_q[AW-1:0];
    assign rd_addr  = rd_q[AW-1:0];
    assign occ      = wr_q - rd_q;
    assign occ_next = wr_d - rd_d;

    // R3
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CAP);

    // R7
    rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (rd_q == '0) && $stable(wr_q));
endmodule

// File: rtl/fifo_level_fsm.sv
module fifo_level_fsm
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [AW:0] occ_next,
    output logic        empty,
    output logic        full,
    output logic        half_full
);
    localparam logic [AW:0] CAP  = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF = (AW+1)'(DEPTH / 2);

    level_e state_q, state_d;

    always_comb begin
        if (occ_next == '0)       state_d = LVL_EMPTY;
        else if (occ_next == CAP) state_d = LVL_FULL;
        else if (occ_next > HALF) state_d = LVL_UPPER;
        else                      state_d = LVL_LOWER;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        empty     = 1'b0;
        full      = 1'b0;
        half_full = 1'b0;
        unique case (state_q)
            LVL_EMPTY: empty = 1'b1;
            LVL_LOWER: ;
            LVL_UPPER: half_full = 1'b1;
            LVL_FULL: begin
                full      = 1'b1;
                half_full = 1'b1;
            end
            default: ;
        endcase
    end

    // R1
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] din,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  dout <= '0;
        else if (re) dout <= mem[raddr];
    end

    // R4
    hold_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(dout));
endmodule

// File: rtl/fifo_rt_hf.sv
module fifo_rt_hf #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rexmit_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             half_full
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] HALF = (AW+1)'(DEPTH / 2);

    logic          wr_go, rd_go, rewind;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [AW:0]   occ, occ_next;

    initial begin
        depth_legal_chk: assert (DEPTH == 256 || DEPTH == 512 || DEPTH == 1024)
            else $error("unsupported DEPTH %0d", DEPTH);
    end

    assign rewind = !rexmit_n;
    assign wr_go  = !wr_n && !full && rexmit_n;
    assign rd_go  = !rd_n && !empty && rexmit_n;

    fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .rd_go(rd_go),
        .rewind(rewind), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .occ(occ), .occ_next(occ_next)
    );

    fifo_level_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .occ_next(occ_next),
        .empty(empty), .full(full), .half_full(half_full)
    );

    fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_go), .waddr(wr_addr), .din(din),
        .re(rd_go), .raddr(rd_addr), .dout(dout)
    );

    // R5
    half_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_full == (occ > HALF));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !wr_n && rd_n && rexmit_n) |=> full && $stable(occ));

    // R8
    rexmit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rexmit_n |=> $stable(dout));
endmodule

// File: tb/fifo_rt_hf_bench.sv
`timescale 1ns/1ps
module fifo_rt_hf_bench;
    localparam int WIDTH = 9;
    localparam int DEPTH = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_n = 1'b1, rd_n = 1'b1, rexmit_n = 1'b1;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;
    logic empty, full, half_full;

    int checks = 0;
    int errors = 0;
    int wcnt = 0;
    int rcnt = 0;
    logic [WIDTH-1:0] exp_dout = '0;

    always #4 clk = ~clk;

    fifo_rt_hf #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo_rt_hf (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
        .rexmit_n(rexmit_n), .din(din), .dout(dout),
        .empty(empty), .full(full), .half_full(half_full)
    );

    function automatic logic [WIDTH-1:0] pat(input int i);
        return WIDTH'((i * 37 + 11) % 512);
    endfunction

    task automatic chk(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        int occ;
        occ = wcnt - rcnt;
        chk(int'(empty), int'(occ == 0), tag, "empty");
        chk(int'(full), int'(occ == DEPTH), tag, "full");
        chk(int'(half_full), int'(occ > DEPTH / 2), tag, "half_full");
        chk(int'(dout), int'(exp_dout), tag, "dout");
    endtask

    // Entered at a falling edge; drives for one rising edge, then checks.
    task automatic step(input bit w, input bit r, input bit t, input bit junk,
                        input string tag);
        int occ;
        wr_n = !w; rd_n = !r; rexmit_n = !t;
        din = junk ? 9'h0AA : pat(wcnt);
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; rexmit_n = 1'b1;
        occ = wcnt - rcnt;
        if (t) begin
            rcnt = 0;
        end else begin
            if (r && occ > 0) begin
                exp_dout = pat(rcnt);
                rcnt++;
            end
            if (w && occ < DEPTH) wcnt++;
        end
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        // R4: reads on an empty buffer
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R4");
        // R5 and R3: fill one word at a time across the half and full marks
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, "R5");
        chk(int'(full), 1, "R3", "full after DEPTH writes");
        // R3: writes while full are dropped
        for (int i = 0; i < 2; i++) step(1, 0, 0, 1, "R3");
        // R6: read and write together while full, write dropped
        step(1, 1, 0, 1, "R6");
        // R2: ordered readout, crossing the half mark downward
        for (int i = 0; i < 140; i++) step(0, 1, 0, 0, "R2");
        // R8: replay with both strobes low; strobes ignored
        step(1, 1, 1, 0, "R8");
        // R7: replay restores the full DEPTH words from the first one
        chk(int'(full), 1, "R7", "full after replay");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, "R7");
        step(0, 1, 0, 0, "R4");
        // R6: concurrent traffic at low occupancy
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R6");
        for (int i = 0; i < 40; i++) step(1, 1, 0, 0, "R6");
        // R6: read and write together on an empty buffer
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R2");
        step(1, 1, 0, 0, "R6");
        step(0, 1, 0, 0, "R2");
        step(0, 1, 0, 0, "R4");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule